// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage that sits beside a working register (W) in a small 8-bit processor core. Each cycle in which `op_valid` is high it takes an operation code, the current W value, a value read from a file register and an 8-bit literal. It computes one result, latches it with a destination select (W or the file register), and updates its own zero, nibble-carry and carry flags. Instruction decode and the storage of W and the file registers sit outside the block.

Two-operand operations always use W as one operand. The other operand is the file value or the literal, chosen by `b_sel`. Single-operand operations work on the file value or on W, again chosen by `b_sel`. The carry flag is kept inside the block, so rotates shift through it. Each flag changes only on the operations that define it. All other operations leave it as it was.

Top module: `alu8_acc`

## Requirements
- R1: While `rst_n` is low, `res_out` is 0, `res_dest` is 0, `res_valid` is 0, and `z_flag`, `dc_flag` and `c_flag` are all 0.
- R2: When `op_valid` is high with a legal code (0 to 12) at a rising edge, `res_valid` is high after that edge and `res_dest` equals the `dest_sel` that was presented. A cycle with `op_valid` low gives `res_valid` low and changes no flag.
- R3: Code 0 (add) gives W + B. Here B is `f_in` when `b_sel`=0 and `k_in` when `b_sel`=1. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is 0.
- R4: Code 1 (subtract) gives B − W, with B selected as in R3. C=1 means no borrow, DC=1 means no borrow out of the low nibble, and Z is set when the result is 0.
- R5: Codes 2 (AND), 3 (OR), 4 (XOR) and 12 (move B) use B as selected in R3. Code 12 gives B unchanged. Only Z is updated; DC and C keep their values.
- R6: Codes 5 (complement), 6 (increment, wrapping) and 7 (decrement, wrapping) act on a single operand: `f_in` when `b_sel`=0, or `w_in` when `b_sel`=1. Only Z is updated.
- R7: Code 8 rotates the single operand (chosen as in R6) left through C: the old C enters bit 0 and bit 7 becomes the new C. Code 9 rotates right through C: the old C enters bit 7 and bit 0 becomes the new C. Z and DC keep their values.
- R8: Code 10 swaps the high and low nibbles of the single operand (chosen as in R6) and changes no flag.
- R9: Code 11 gives a result of 0 and sets Z, whatever the operands are. DC and C keep their values.
- R10: Codes 13 to 15 are reserved. With `op_valid` high they give `res_valid` low, leave `res_out` and `res_dest` at their previous values, and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| b_sel | input | 1 | Operand choice: file/literal for two-operand codes, file/W for single-operand codes |
| dest_sel | input | 1 | Destination for the result: 0 W, 1 file register |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File register value |
| k_in | input | 8 | Literal operand |
| res_out | output | 8 | Registered result |
| res_dest | output | 1 | Registered destination select |
| res_valid | output | 1 | Result registered on the previous edge |
| z_flag | output | 1 | Zero flag |
| dc_flag | output | 1 | Low-nibble carry / no-borrow flag |
| c_flag | output | 1 | Carry / no-borrow flag |

## Verification
The assertions check the per-operation flag rules on every cycle. A logic, move, increment or decrement operation never touches C or DC. Rotates leave Z and DC alone, and swap and reserved codes freeze all flags. Z always agrees with a zero result after each operation that defines Z, and clear always yields zero with Z set. The exact sums, differences, borrow senses, nibble carries and the bit that a rotate shifts in through C depend on operand values and on the history of the carry flag. Only the bench's sequence of vectors, with flags carried from one vector to the next, can show these.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_SWAP = 4'd10,
    OP_CLR  = 4'd11,
    OP_MOV  = 4'd12
  } alu_op_e;

  localparam logic [3:0] OP_LAST_LEGAL = 4'd12;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } alu_flags_t;

  // Single-operand codes choose between file (0) and W (1).
  function automatic logic op_is_single(input logic [3:0] op);
    return (op >= OP_COM) && (op <= OP_SWAP);
  endfunction

  function automatic logic op_is_legal(input logic [3:0] op);
    return op <= OP_LAST_LEGAL;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu8_opnd_sel.sv
module alu8_opnd_sel
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_code,
  input  logic             b_sel,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] f_in,
  input  logic [WIDTH-1:0] k_in,
  output logic [WIDTH-1:0] opnd
);

  logic single_op;

  always_comb begin
    single_op = op_is_single(op_code);
    if (!b_sel) begin
      opnd = f_in;
    end else if (single_op) begin
      opnd = w_in;
    end else begin
      opnd = k_in;
    end
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic             sub_en,
  input  logic [WIDTH-1:0] w_val,
  input  logic [WIDTH-1:0] b_val,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             dc_out
);

  localparam int NIB = WIDTH / 2;

  logic [WIDTH-1:0] w_eff;
  logic [WIDTH:0]   full_sum;
  logic [NIB:0]     low_sum;

  always_comb begin
    // Subtract is B + ~W + 1, so carry out means no borrow.
    w_eff    = sub_en ? ~w_val : w_val;
    full_sum = {1'b0, b_val} + {1'b0, w_eff} + {{WIDTH{1'b0}}, sub_en};
    low_sum  = {1'b0, b_val[NIB-1:0]} + {1'b0, w_eff[NIB-1:0]} + {{NIB{1'b0}}, sub_en};
    sum      = full_sum[WIDTH-1:0];
    c_out    = full_sum[WIDTH];
    dc_out   = low_sum[NIB];
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] w_val,
  input  logic [WIDTH-1:0] b_val,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             rot_c
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  for (genvar i = 0; i < HALF; i++) begin : g_swap
    assign swapped[i]      = b_val[i+HALF];
    assign swapped[i+HALF] = b_val[i];
  end

  always_comb begin
    case (op_code)
      OP_AND:  res = w_val & b_val;
      OP_OR:   res = w_val | b_val;
      OP_XOR:  res = w_val ^ b_val;
      OP_COM:  res = ~b_val;
      OP_INC:  res = b_val + WIDTH'(1);
      OP_DEC:  res = b_val - WIDTH'(1);
      OP_RLC:  res = {b_val[WIDTH-2:0], c_in};
      OP_RRC:  res = {c_in, b_val[WIDTH-1:1]};
      OP_SWAP: res = swapped;
      OP_MOV:  res = b_val;
      default: res = '0;
    endcase
    rot_c = (op_code == OP_RLC) ? b_val[WIDTH-1] : b_val[0];
  end

endmodule

// File: rtl/alu8_flag_upd.sv
module alu8_flag_upd
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] res,
  input  logic             arith_c,
  input  logic             arith_dc,
  input  logic             rot_c,
  input  alu_flags_t       flags_q,
  output alu_flags_t       flags_d
);

  logic res_zero;

  always_comb begin
    res_zero = (res == '0);
    flags_d  = flags_q;
    case (op_code)
      OP_ADD, OP_SUB: begin
        flags_d.z  = res_zero;
        flags_d.dc = arith_dc;
        flags_d.c  = arith_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_MOV: begin
        flags_d.z = res_zero;
      end
      OP_CLR: begin
        flags_d.z = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        flags_d.c = rot_c;
      end
      default: begin
        flags_d = flags_q;
      end
    endcase
  end

endmodule

// File: rtl/alu8_acc.sv
module alu8_acc
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             b_sel,
  input  logic             dest_sel,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] f_in,
  input  logic [WIDTH-1:0] k_in,
  output logic [WIDTH-1:0] res_out,
  output logic             res_dest,
  output logic             res_valid,
  output logic             z_flag,
  output logic             dc_flag,
  output logic             c_flag
);

  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] as_sum;
  logic [WIDTH-1:0] bo_res;
  logic [WIDTH-1:0] res_d;
  logic             as_c;
  logic             as_dc;
  logic             bo_c;
  logic             upd_en;
  alu_flags_t       flg_q;
  alu_flags_t       flg_d;

  alu8_opnd_sel #(.WIDTH(WIDTH)) u_opnd (
    .op_code (op_code),
    .b_sel   (b_sel),
    .w_in    (w_in),
    .f_in    (f_in),
    .k_in    (k_in),
    .opnd    (opnd)
  );

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .sub_en (op_code == OP_SUB),
    .w_val  (w_in),
    .b_val  (opnd),
    .sum    (as_sum),
    .c_out  (as_c),
    .dc_out (as_dc)
  );

  alu8_bitops #(.WIDTH(WIDTH)) u_bitops (
    .op_code (op_code),
    .w_val   (w_in),
    .b_val   (opnd),
    .c_in    (flg_q.c),
    .res     (bo_res),
    .rot_c   (bo_c)
  );

  always_comb begin
    res_d  = op_is_arith(op_code) ? as_sum : bo_res;
    upd_en = op_valid && op_is_legal(op_code);
  end

  alu8_flag_upd #(.WIDTH(WIDTH)) u_flags (
    .op_code  (op_code),
    .res      (res_d),
    .arith_c  (as_c),
    .arith_dc (as_dc),
    .rot_c    (bo_c),
    .flags_q  (flg_q),
    .flags_d  (flg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_out   <= '0;
      res_dest  <= 1'b0;
      flg_q     <= '0;
    end else begin
      res_valid <= upd_en;
      if (upd_en) begin
        res_out  <= res_d;
        res_dest <= dest_sel;
        flg_q    <= flg_d;
      end
    end
  end

  assign z_flag  = flg_q.z;
  assign dc_flag = flg_q.dc;
  assign c_flag  = flg_q.c;

endmodule

// File: rtl/alu8_acc_chk.sv
module alu8_acc_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic             res_valid,
  input logic [WIDTH-1:0] res_out,
  input logic             z_flag,
  input logic             dc_flag,
  input logic             c_flag
);

  AST_LEGAL_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 4'd12) |=> res_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable({z_flag, dc_flag, c_flag}))); // R2

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code <= 4'd7 || op_code == 4'd11 || op_code == 4'd12))
      |=> (z_flag == (res_out == '0))); // R3

  AST_LOGIC_KEEPS_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ((op_code >= 4'd2 && op_code <= 4'd7) || op_code == 4'd12))
      |=> ($stable(c_flag) && $stable(dc_flag))); // R5

  AST_ROTATE_KEEPS_Z_DC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd8 || op_code == 4'd9))
      |=> ($stable(z_flag) && $stable(dc_flag))); // R7

  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd10) |=> $stable({z_flag, dc_flag, c_flag})); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd11)
      |=> (res_out == '0 && z_flag && $stable(c_flag) && $stable(dc_flag))); // R9

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 4'd12)
      |=> (!res_valid && $stable(res_out) && $stable({z_flag, dc_flag, c_flag}))); // R10

endmodule

bind alu8_acc alu8_acc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .res_valid (res_valid),
  .res_out   (res_out),
  .z_flag    (z_flag),
  .dc_flag   (dc_flag),
  .c_flag    (c_flag)
);

// File: tb/alu8_acc_tb.sv
module alu8_acc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  // op[40:37] b_sel[36] dest[35] w[34:27] f[26:19] k[18:11] res[10:3] z[2] dc[1] c[0]
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 1'b1, 8'h3A, 8'h47, 8'h00, 8'h81, 3'b010},
    {4'd0,  1'b1, 1'b0, 8'hF0, 8'h00, 8'h10, 8'h00, 3'b101},
    {4'd1,  1'b0, 1'b1, 8'h06, 8'h05, 8'h00, 8'hFF, 3'b000},
    {4'd1,  1'b1, 1'b0, 8'h20, 8'h00, 8'h20, 8'h00, 3'b111},
    {4'd2,  1'b0, 1'b1, 8'h0F, 8'hF0, 8'h00, 8'h00, 3'b111},
    {4'd4,  1'b1, 1'b0, 8'h0F, 8'h00, 8'hAA, 8'hA5, 3'b011},
    {4'd8,  1'b0, 1'b1, 8'h00, 8'h80, 8'h00, 8'h01, 3'b011},
    {4'd9,  1'b1, 1'b0, 8'h02, 8'h00, 8'h00, 8'h81, 3'b010},
    {4'd6,  1'b0, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 3'b110},
    {4'd7,  1'b1, 1'b0, 8'h00, 8'h55, 8'h00, 8'hFF, 3'b010},
    {4'd10, 1'b0, 1'b1, 8'h00, 8'h3C, 8'h00, 8'hC3, 3'b010},
    {4'd5,  1'b0, 1'b0, 8'h00, 8'h5A, 8'h00, 8'hA5, 3'b010},
    {4'd11, 1'b0, 1'b1, 8'h12, 8'h34, 8'h56, 8'h00, 3'b110},
    {4'd3,  1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 3'b110},
    {4'd12, 1'b1, 1'b1, 8'h00, 8'h00, 8'h7E, 8'h7E, 3'b010},
    {4'd1,  1'b0, 1'b0, 8'h01, 8'h10, 8'h00, 8'h0F, 3'b001},
    {4'd12, 1'b0, 1'b1, 8'hAA, 8'h00, 8'hFF, 8'h00, 3'b101}
  };

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic       b_sel;
  logic       dest_sel;
  logic [7:0] w_in;
  logic [7:0] f_in;
  logic [7:0] k_in;
  logic [7:0] res_out;
  logic       res_dest;
  logic       res_valid;
  logic       z_flag;
  logic       dc_flag;
  logic       c_flag;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  alu8_acc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .b_sel     (b_sel),
    .dest_sel  (dest_sel),
    .w_in      (w_in),
    .f_in      (f_in),
    .k_in      (k_in),
    .res_out   (res_out),
    .res_dest  (res_dest),
    .res_valid (res_valid),
    .z_flag    (z_flag),
    .dc_flag   (dc_flag),
    .c_flag    (c_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0:                 return "R3";
      4'd1:                 return "R4";
      4'd2, 4'd3, 4'd4, 4'd12: return "R5";
      4'd5, 4'd6, 4'd7:     return "R6";
      4'd8, 4'd9:           return "R7";
      4'd10:                return "R8";
      default:              return "R9";
    endcase
  endfunction

  task automatic drive_op(input logic [3:0] op, input logic bs, input logic ds,
                          input logic [7:0] w, input logic [7:0] f, input logic [7:0] k);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    b_sel    = bs;
    dest_sel = ds;
    w_in     = w;
    f_in     = f;
    k_in     = k;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = 4'd0;
    b_sel    = 1'b0;
    dest_sel = 1'b0;
    w_in     = 8'h00;
    f_in     = 8'h00;
    k_in     = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", "res_valid", 32'(res_valid), 32'd0);
    check("R1", "res_out",   32'(res_out),   32'd0);
    check("R1", "res_dest",  32'(res_dest),  32'd0);
    check("R1", "flags",     32'({z_flag, dc_flag, c_flag}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table, flags carried from one entry to the next.
    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      string       rq;
      v  = VEC[i];
      rq = req_of(v[40:37]);
      drive_op(v[40:37], v[36], v[35], v[34:27], v[26:19], v[18:11]);
      check("R2", "res_valid", 32'(res_valid), 32'd1);
      check("R2", "res_dest",  32'(res_dest),  32'(v[35]));
      check(rq,   "res_out",   32'(res_out),   32'(v[10:3]));
      check(rq,   "flags z/dc/c", 32'({z_flag, dc_flag, c_flag}), 32'(v[2:0]));
    end

    // Idle cycle: no result, flags hold (last vector left z=1 dc=0 c=1).
    @(negedge clk);
    check("R2", "idle res_valid", 32'(res_valid), 32'd0);
    check("R2", "idle flags", 32'({z_flag, dc_flag, c_flag}), 32'b101);

    // Reserved codes: ignored, result and flags unchanged.
    for (int rc = 13; rc < 16; rc++) begin
      drive_op(4'(rc), 1'b1, 1'b0, 8'hFF, 8'hFF, 8'h01);
      check("R10", "reserved res_valid", 32'(res_valid), 32'd0);
      check("R10", "reserved res_out",   32'(res_out),   32'h00);
      check("R10", "reserved res_dest",  32'(res_dest),  32'd1);
      check("R10", "reserved flags", 32'({z_flag, dc_flag, c_flag}), 32'b101);
    end

    // Rotate left with C=1 shifting into bit 0, carry from bit 7 = 0.
    drive_op(4'd8, 1'b1, 1'b0, 8'h40, 8'h00, 8'h00);
    check("R7", "rlc res", 32'(res_out), 32'h81);
    check("R7", "rlc flags", 32'({z_flag, dc_flag, c_flag}), 32'b100);

    // Add with only a low-nibble carry: 0x08 + 0x08.
    drive_op(4'd0, 1'b1, 1'b0, 8'h08, 8'h00, 8'h08);
    check("R3", "add dc res", 32'(res_out), 32'h10);
    check("R3", "add dc flags", 32'({z_flag, dc_flag, c_flag}), 32'b010);

    // Reset in mid-run clears everything again.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mid reset res_out", 32'(res_out), 32'd0);
    check("R1", "mid reset flags", 32'({z_flag, dc_flag, c_flag}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule